// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Acceptor

This block gathers interrupt requests from five sources: a DMA engine, an external pin, a timer, a vertical-sync input and a serial port. Each source has a request flag that the block latches. A source takes part in arbitration only while its flag is set and software has granted it permission through a per-source mask bit.

A single global enable bit gates every acceptance. The processor sets it with an enable command and clears it with a disable command. When the enable bit is on and at least one source is eligible, an acknowledge token travels down a chain of stages in fixed priority order. The first eligible stage keeps the token. That stage then clears its own request flag and supplies its own vector address, which the block presents with a one-cycle strobe.

Acceptance turns the global enable off again. A second acceptance therefore needs a fresh enable command from the interrupt handler.

Top module: `irq_daisy_acceptor`

## Requirements
- R1: After reset, all request flags are 0, all permission bits are 0 (all sources masked), the enable bit is 0, `acceptStb` and `grantOh` are 0 and `vectorOut` is 0.
- R2: Any `periphReq[i]` high at a clock edge sets request flag i at that edge. The pin source (index 1) also sets its flag on a 0-to-1 change of `pinLevel`. A level that stays high sets the flag once only.
- R3: When `permitWe` is high, the permission bits load from `permitData`, with bit i belonging to source i. A source is eligible only while both its flag and its permission bit are 1.
- R4: `eiCmd` sets the enable bit and `diCmd` clears it. If both are high in the same cycle, `diCmd` wins. No acceptance happens while the enable bit is 0.
- R5: The priority is fixed, with index 0 highest: DMA (0), pin (1), timer (2), vertical sync (3), serial (4). Exactly one source is granted per acceptance.
- R6: An acceptance happens at an edge where the enable bit is 1 and some source is eligible. In the following cycle, `acceptStb` is 1, `grantOh` has the winner's bit set, and `vectorOut` equals `VEC_BASE + i*VEC_STEP`. The winner's flag is cleared at that edge and all other flags keep their values. `vectorOut` holds its value until the next acceptance.
- R7: `acceptStb` is high for exactly one cycle per acceptance.
- R8: An acceptance clears the enable bit. This takes priority over an `eiCmd` presented at the same edge.
- R9: A set flag whose source is masked, or which loses arbitration, stays pending and is visible on `reqPending`.
- R10: If a new request for the winning source arrives at the accepting edge, the flag stays set, so the event is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periphReq | input | NUM_SRC | Per-source request events |
| pinLevel | input | 1 | External interrupt pin level (rising edge requests source 1) |
| permitWe | input | 1 | Load strobe for permission bits |
| permitData | input | NUM_SRC | New permission bits |
| eiCmd | input | 1 | Set global enable |
| diCmd | input | 1 | Clear global enable |
| acceptStb | output | 1 | One-cycle acceptance strobe |
| vectorOut | output | VEC_W | Vector address of the last accepted source |
| grantOh | output | NUM_SRC | One-hot winner, valid with `acceptStb` |
| reqPending | output | NUM_SRC | Current request flags |
| intEnable | output | 1 | Global enable bit |

## Verification
- **Flag timing:** A request event driven before edge k shows up on `reqPending` just after edge k.
- **Acceptance timing:** If the enable bit is already on, the acceptance is decided at edge k+1. The strobe, one-hot grant and vector are then visible for the single cycle after edge k+1. The enable bit reads 0 from that same point.
- **Sampling:** Inputs change one time step after a rising edge. The outputs are sampled on the falling edge, so every sample lands mid-cycle at the intended count.
- **Scoreboard:** The driver queues the expected vector and grant before the edges that produce them. Any strobe with an empty queue, or with a mismatched vector or grant, is counted as a failure.
- **Flag and enable checks:** These are read two cycles after an enable command, which is when an acceptance that enable allows has finished.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  // Strobes sent from control to the datapath.
  typedef struct packed {
    logic accept;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_accept_dp.sv
module irq_accept_dp
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int VEC_W = 12,
  parameter int PIN_IDX = 1,
  parameter logic [VEC_W-1:0] VEC_BASE = 12'h040,
  parameter logic [VEC_W-1:0] VEC_STEP = 12'h008
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] periphReq,
  input  logic               pinLevel,
  input  logic               permitWe,
  input  logic [NUM_SRC-1:0] permitData,
  input  ctrlStrobe_t        strobe,
  output logic               anyReq,
  output logic [NUM_SRC-1:0] reqPending,
  output logic               acceptStb,
  output logic [VEC_W-1:0]   vectorOut,
  output logic [NUM_SRC-1:0] grantOh
);

  logic               pinPrev;
  logic               pinRise;
  logic [NUM_SRC-1:0] setEv;
  logic [NUM_SRC-1:0] reqFlag;
  logic [NUM_SRC-1:0] permitQ;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] ackChain;
  logic [NUM_SRC-1:0] grantNow;
  logic [VEC_W-1:0]   vecNext;

  assign pinRise = pinLevel & ~pinPrev;

  // Per-source request events; the pin source also sees the pin edge.
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSet
    if (i == PIN_IDX) begin : gPin
      assign setEv[i] = periphReq[i] | pinRise;
    end else begin : gPlain
      assign setEv[i] = periphReq[i];
    end
  end

  assign eligible = reqFlag & permitQ;
  assign anyReq   = |eligible;

  // Acknowledge chain: index 0 sees the token first.
  assign ackChain[0] = strobe.accept;
  for (genvar i = 0; i < NUM_SRC; i++) begin : gChain
    assign grantNow[i] = ackChain[i] & eligible[i];
    if (i < NUM_SRC - 1) begin : gPass
      assign ackChain[i+1] = ackChain[i] & ~eligible[i];
    end
  end

  always_comb begin
    vecNext = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grantNow[i]) vecNext = vecNext | (VEC_BASE + VEC_W'(i) * VEC_STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev   <= 1'b0;
      reqFlag   <= '0;
      permitQ   <= '0;
      acceptStb <= 1'b0;
      grantOh   <= '0;
      vectorOut <= '0;
    end else begin
      pinPrev   <= pinLevel;
      // A new event wins over the clear from acceptance.
      reqFlag   <= setEv | (reqFlag & ~grantNow);
      if (permitWe) permitQ <= permitData;
      acceptStb <= strobe.accept;
      grantOh   <= grantNow;
      if (strobe.accept) vectorOut <= vecNext;
    end
  end

  assign reqPending = reqFlag;

  // R5: at most one winner
  a_r5_onehot_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh));

  // R3: the winner was permitted and pending at the accepting edge
  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |-> ((grantOh & ~($past(permitQ) & $past(reqFlag))) == '0));

  // R9: a flag that is not granted stays set
  for (genvar i = 0; i < NUM_SRC; i++) begin : gKeep
    a_r9_pending_kept: assert property (@(posedge clk) disable iff (!rstN)
      (reqFlag[i] && !grantNow[i]) |=> reqFlag[i]);
  end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        eiCmd,
  input  logic        diCmd,
  input  logic        anyReq,
  output ctrlStrobe_t strobe,
  output logic        intEnable
);

  logic enQ;

  always_comb begin
    strobe        = '0;
    strobe.accept = enQ & anyReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0;
    end else if (strobe.accept || diCmd) begin
      enQ <= 1'b0;
    end else if (eiCmd) begin
      enQ <= 1'b1;
    end
  end

  assign intEnable = enQ;

  // R4: an enable command alone (no disable, no acceptance) turns the enable on
  a_r4_ei_sets: assert property (@(posedge clk) disable iff (!rstN)
    (eiCmd && !diCmd && !anyReq) |=> enQ);

endmodule

// File: rtl/irq_daisy_acceptor.sv
module irq_daisy_acceptor
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int VEC_W = 12,
  parameter int PIN_IDX = 1,
  parameter logic [VEC_W-1:0] VEC_BASE = 12'h040,
  parameter logic [VEC_W-1:0] VEC_STEP = 12'h008
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] periphReq,
  input  logic               pinLevel,
  input  logic               permitWe,
  input  logic [NUM_SRC-1:0] permitData,
  input  logic               eiCmd,
  input  logic               diCmd,
  output logic               acceptStb,
  output logic [VEC_W-1:0]   vectorOut,
  output logic [NUM_SRC-1:0] grantOh,
  output logic [NUM_SRC-1:0] reqPending,
  output logic               intEnable
);

  ctrlStrobe_t strobe;
  logic        anyReq;

  irq_accept_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .eiCmd     (eiCmd),
    .diCmd     (diCmd),
    .anyReq    (anyReq),
    .strobe    (strobe),
    .intEnable (intEnable)
  );

  irq_accept_dp #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .PIN_IDX  (PIN_IDX),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .periphReq  (periphReq),
    .pinLevel   (pinLevel),
    .permitWe   (permitWe),
    .permitData (permitData),
    .strobe     (strobe),
    .anyReq     (anyReq),
    .reqPending (reqPending),
    .acceptStb  (acceptStb),
    .vectorOut  (vectorOut),
    .grantOh    (grantOh)
  );

  // R8: enable reads 0 whenever the strobe is shown
  a_r8_enable_cleared: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |-> !intEnable);

  // R7: strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |=> !acceptStb);

  // R4: a disable command blocks any strobe two edges later
  a_r4_di_blocks: assert property (@(posedge clk) disable iff (!rstN)
    diCmd |=> ##1 !acceptStb);

endmodule

// File: tb/test_irq_daisy_acceptor.sv
module test_irq_daisy_acceptor;

  localparam int NS = 5;
  localparam int VW = 12;
  localparam logic [VW-1:0] VBASE = 12'h040;
  localparam logic [VW-1:0] VSTEP = 12'h008;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] periphReq = '0;
  logic          pinLevel = 1'b0;
  logic          permitWe = 1'b0;
  logic [NS-1:0] permitData = '0;
  logic          eiCmd = 1'b0;
  logic          diCmd = 1'b0;
  logic          acceptStb;
  logic [VW-1:0] vectorOut;
  logic [NS-1:0] grantOh;
  logic [NS-1:0] reqPending;
  logic          intEnable;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [VW-1:0] vec;
    logic [NS-1:0] oh;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  irq_daisy_acceptor i_irq_daisy_acceptor (
    .clk(clk), .rstN(rstN), .periphReq(periphReq), .pinLevel(pinLevel),
    .permitWe(permitWe), .permitData(permitData), .eiCmd(eiCmd), .diCmd(diCmd),
    .acceptStb(acceptStb), .vectorOut(vectorOut), .grantOh(grantOh),
    .reqPending(reqPending), .intEnable(intEnable)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    periphReq = m;
    tick(1);
    periphReq = '0;
  endtask

  task automatic ei();
    eiCmd = 1'b1;
    tick(1);
    eiCmd = 1'b0;
  endtask

  task automatic di();
    diCmd = 1'b1;
    tick(1);
    diCmd = 1'b0;
  endtask

  task automatic setPermit(input logic [NS-1:0] m);
    permitData = m;
    permitWe = 1'b1;
    tick(1);
    permitWe = 1'b0;
  endtask

  // Driver side of the scoreboard: queue the expected vector and grant.
  task automatic expectSrc(input int idx);
    exp_t e;
    e.vec = VBASE + VW'(idx) * VSTEP;
    e.oh  = NS'(1) << idx;
    expQ.push_back(e);
  endtask

  // Monitor side: compare every strobe against the queue.
  always @(negedge clk) begin
    if (rstN && acceptStb) begin
      if (expQ.size() == 0) begin
        nRun++;
        nFail++;
        $display("FAIL R7: unexpected strobe, actual vector %h expected none", vectorOut);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chkEq("R6 vector", 32'(vectorOut), 32'(e.vec));
        chkEq("R5 grant", 32'(grantOh), 32'(e.oh));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 pending", 32'(reqPending), 0);
    chkEq("R1 enable", 32'(intEnable), 0);
    chkEq("R1 strobe", 32'(acceptStb), 0);
    chkEq("R1 vector", 32'(vectorOut), 0);
    chkEq("R1 grant", 32'(grantOh), 0);
    tick(1);

    // R3: masked after reset, no acceptance even when enabled
    pulse(5'b00100);
    ei();
    tick(3);
    chkEq("R3 masked pending", 32'(reqPending), 32'h04);
    di();
    setPermit(5'h1F);
    expectSrc(2);
    ei();
    tick(2);
    chkEq("R6 timer cleared", 32'(reqPending), 0);
    chkEq("R8 enable off", 32'(intEnable), 0);

    // R5: all five at once, served in priority order
    pulse(5'h1F);
    chkEq("R2 all set", 32'(reqPending), 32'h1F);
    for (int i = 0; i < NS; i++) begin
      expectSrc(i);
      ei();
      tick(2);
      chkEq("R5 order pending", 32'(reqPending), 32'(5'h1F & ~((5'd2 << i) - 5'd1)));
    end

    // R9: a masked high-priority flag stays pending while a lower one wins
    setPermit(5'h1E);
    pulse(5'b10001);
    expectSrc(4);
    ei();
    tick(2);
    chkEq("R9 masked kept", 32'(reqPending), 32'h01);
    tick(3);
    chkEq("R9 still kept", 32'(reqPending), 32'h01);
    setPermit(5'h1F);
    expectSrc(0);
    ei();
    tick(2);
    chkEq("R9 served later", 32'(reqPending), 0);

    // R2: pin rising edge sets once; a steady high does not re-set
    pinLevel = 1'b1;
    tick(1);
    chkEq("R2 pin edge", 32'(reqPending), 32'h02);
    expectSrc(1);
    ei();
    tick(2);
    ei();
    tick(4);
    chkEq("R2 steady high", 32'(reqPending), 0);
    di();
    pinLevel = 1'b0;
    tick(1);
    pinLevel = 1'b1;
    tick(1);
    chkEq("R2 second edge", 32'(reqPending), 32'h02);
    expectSrc(1);
    ei();
    tick(2);

    // R4: enable and disable together leaves the enable off
    eiCmd = 1'b1;
    diCmd = 1'b1;
    tick(1);
    eiCmd = 1'b0;
    diCmd = 1'b0;
    chkEq("R4 di wins", 32'(intEnable), 0);
    pulse(5'b00100);
    tick(3);
    chkEq("R4 held off", 32'(reqPending), 32'h04);
    expectSrc(2);
    ei();
    tick(2);
    chkEq("R4 after ei", 32'(reqPending), 0);

    // R8: acceptance beats an enable command at the same edge
    pulse(5'b01000);
    expectSrc(3);
    eiCmd = 1'b1;
    tick(2);
    eiCmd = 1'b0;
    chkEq("R8 accept beats ei", 32'(intEnable), 0);

    // R10: new event at the accepting edge keeps the flag
    pulse(5'b00001);
    expectSrc(0);
    ei();
    periphReq = 5'b00001;
    tick(1);
    periphReq = '0;
    chkEq("R10 flag kept", 32'(reqPending), 32'h01);
    expectSrc(0);
    ei();
    tick(2);
    chkEq("R10 second accept", 32'(reqPending), 0);

    tick(3);
    chkEq("R6 queue drained", 32'(expQ.size()), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule